// File: doc/BRIEF.md
# Shared-Wire Load Current Exchange Node

This block sits in each of several power-supply controllers that share one open-drain wire. It places its load-current word on the wire in repeating frames. A frame is one start slot, eight data slots and one stop slot. In the start slot the wire is low. The data slots carry the word with the most significant bit first. In the stop slot the wire is released, so it reads high. The word sent is the top byte of one of two 16-bit current readings, and a select input chooses which one. Contention is settled bit by bit through wired-AND arbitration. A node that releases the wire for a 1 but reads a 0 back stops driving until the frame ends. As a result, every node receives the smallest word offered in that frame. That word is held in a share register and is available to the regulation logic.

The slots are paced by an external bit-tick strobe. On each tick the node samples the wire for the slot that has just ended, and it sets its drive for the next slot. The node can be connected to a wire that is already carrying frames. In that case it stays silent until it has seen a stop bit: at least `WORD_W+1` released slots in a row. Inside a frame the wire can only be released that long if the run includes the stop slot. After that, the next low slot on the wire is taken as a start, and the node joins the exchange from that frame on. A synchronised node that finds the wire released for `START_RUN` slots begins a frame itself. This lets a single node run alone.

Top module: `share_bus_node`

## Requirements
- R1: A synchronous active-low reset releases the wire (`bus_drive_low`=0), clears `share_word` to 0 and leaves the node unsynchronised. A reset that arrives in the middle of a frame also releases the wire in the cycle that follows it.
- R2: The word transmitted in a frame is bits [15:8] of `cur_a` when `chan_sel`=0, or bits [15:8] of `cur_b` when `chan_sel`=1. It is latched at the tick that ends the start slot. Bits [7:0] of both readings have no effect.
- R3: `bus_drive_low` and `share_word` change only at a clock edge where `bit_tick` is 1. The node always releases the wire during the stop slot.
- R4: In a data slot a node that is still competing drives the wire low for a 0 bit and releases it for a 1 bit. Bit 7 is sent first and bit 0 last.
- R5: A competing node that releases the wire for a 1 bit but samples 0 stays released for the remaining data slots of that frame. The received word is therefore the smallest of the words sent.
- R6: If the stop slot is sampled high, `share_word` loads the 8 bits sampled in the data slots. Otherwise `share_word` holds its value.
- R7: If the stop slot is sampled low, the frame is discarded, `share_word` keeps its old value and the node returns to the unsynchronised state.
- R8: An unsynchronised node never drives the wire. It becomes synchronised at the tick that completes `WORD_W+1` consecutive high samples (9 by default).
- R9: When a synchronised idle node samples a low slot, it treats that slot as a start bit. It then takes part in the frame from bit 7 onward.
- R10: When a synchronised idle node has seen `START_RUN` (default 10) consecutive high samples, it drives a start slot itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_tick | input | 1 | One-cycle strobe marking each slot boundary |
| bus_in | input | 1 | Sampled level of the shared wire |
| bus_drive_low | output | 1 | 1 pulls the shared wire low; 0 releases it |
| cur_a | input | 16 | Current reading, channel 0 |
| cur_b | input | 16 | Current reading, channel 1 |
| chan_sel | input | 1 | Selects the channel whose top byte is sent |
| share_word | output | 8 | Last word received in a valid frame |

## Verification
Every result is registered once, at the clock edge that captures `bit_tick`. A new drive level or a new share word is therefore visible one cycle after the tick is raised. The bench raises each tick at a falling edge, lowers it at the next falling edge, and samples the outputs only after that falling edge. Each data slot is checked against the drive level expected from the node's own word and the arbitration state. The share word is checked once the stop slot's tick has passed. Silence checks run across whole slots, where a stray drive would become visible.

// File: rtl/share_bus_node.sv
module share_bus_node #(
  parameter int WORD_W    = 8,
  parameter int READ_W    = 16,
  parameter int START_RUN = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              bus_in,
  output logic              bus_drive_low,
  input  logic [READ_W-1:0] cur_a,
  input  logic [READ_W-1:0] cur_b,
  input  logic              chan_sel,
  output logic [WORD_W-1:0] share_word
);

  localparam int SYNC_RUN = WORD_W + 1;
  localparam int RUN_W    = $clog2(START_RUN + 1);
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int LOW_W    = READ_W - WORD_W;

  typedef enum logic [2:0] {
    PH_WAIT  = 3'd0,
    PH_IDLE  = 3'd1,
    PH_START = 3'd2,
    PH_DATA  = 3'd3,
    PH_STOP  = 3'd4
  } phase_t;

  phase_t            phase_q;
  logic [RUN_W-1:0]  run_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              arb_q;
  logic              drv_q;
  logic [WORD_W-1:0] share_q;

  logic [WORD_W-1:0] pick;
  logic [RUN_W-1:0]  run_nx;
  logic              tx_bit;
  logic              lose;
  logic              unused_low;

  assign pick   = chan_sel ? cur_b[READ_W-1 -: WORD_W] : cur_a[READ_W-1 -: WORD_W];
  assign run_nx = !bus_in ? '0 :
                  (run_q == RUN_W'(START_RUN)) ? run_q : run_q + 1'b1;
  assign tx_bit = tx_q[idx_q];
  assign lose   = arb_q && tx_bit && !bus_in;
  assign unused_low = ^{cur_a[LOW_W-1:0], cur_b[LOW_W-1:0]};

  assign bus_drive_low = drv_q;
  assign share_word    = share_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_WAIT;
      run_q   <= '0;
      idx_q   <= '0;
      tx_q    <= '0;
      rx_q    <= '0;
      arb_q   <= 1'b0;
      drv_q   <= 1'b0;
      share_q <= '0;
    end else if (bit_tick) begin
      run_q <= run_nx;
      case (phase_q)
        PH_WAIT: begin
          drv_q <= 1'b0;
          if (run_nx >= RUN_W'(SYNC_RUN)) phase_q <= PH_IDLE;
        end
        PH_IDLE: begin
          if (!bus_in) begin
            phase_q <= PH_DATA;
            idx_q   <= IDX_W'(WORD_W - 1);
            tx_q    <= pick;
            arb_q   <= 1'b1;
            drv_q   <= ~pick[WORD_W-1];
          end else if (run_nx >= RUN_W'(START_RUN)) begin
            phase_q <= PH_START;
            drv_q   <= 1'b1;
          end
        end
        PH_START: begin
          phase_q <= PH_DATA;
          idx_q   <= IDX_W'(WORD_W - 1);
          tx_q    <= pick;
          arb_q   <= 1'b1;
          drv_q   <= ~pick[WORD_W-1];
        end
        PH_DATA: begin
          rx_q  <= {rx_q[WORD_W-2:0], bus_in};
          arb_q <= arb_q && !lose;
          if (idx_q == '0) begin
            phase_q <= PH_STOP;
            drv_q   <= 1'b0;
          end else begin
            idx_q <= idx_q - 1'b1;
            drv_q <= arb_q && !lose && !tx_q[idx_q - 1'b1];
          end
        end
        PH_STOP: begin
          drv_q <= 1'b0;
          if (bus_in) begin
            share_q <= rx_q;
            phase_q <= PH_IDLE;
          end else begin
            phase_q <= PH_WAIT;
          end
        end
        default: begin
          phase_q <= PH_WAIT;
          drv_q   <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/share_bus_node_chk.sv
module share_bus_node_chk #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bit_tick,
  input logic              bus_in,
  input logic              bus_drive_low,
  input logic [WORD_W-1:0] share_word,
  input logic [2:0]        phase,
  input logic              tx_bit
);

  AST_RESET_RELEASE: assert property (@(posedge clk) !rst_n |=> (!bus_drive_low && share_word == '0 && phase == 3'd0)); // R1

  AST_DRIVE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> ($stable(bus_drive_low) && $stable(share_word))); // R3

  AST_LOSER_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) (bit_tick && phase == 3'd3 && tx_bit && !bus_in) |=> !bus_drive_low); // R5

  AST_SHARE_ON_HIGH_STOP: assert property (@(posedge clk) disable iff (!rst_n) !(bit_tick && bus_in) |=> $stable(share_word)); // R6

  AST_BAD_STOP_UNSYNC: assert property (@(posedge clk) disable iff (!rst_n) (bit_tick && phase == 3'd4 && !bus_in) |=> (phase == 3'd0)); // R7

  AST_UNSYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (phase == 3'd0) |-> !bus_drive_low); // R8

  AST_JOIN_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n) (bit_tick && phase == 3'd1 && !bus_in) |=> (phase == 3'd3)); // R9

endmodule

bind share_bus_node share_bus_node_chk #(.WORD_W(WORD_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .bus_in       (bus_in),
  .bus_drive_low(bus_drive_low),
  .share_word   (share_word),
  .phase        (phase_q),
  .tx_bit       (tx_bit)
);

// File: tb/share_bus_node_tb_top.sv
`timescale 1ns/1ps
module share_bus_node_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_tick = 1'b0;
  logic        ext_low = 1'b0;
  logic [15:0] cur_a = '0;
  logic [15:0] cur_b = '0;
  logic        chan_sel = 1'b0;
  logic        drv;
  logic [7:0]  share;
  logic        bus_in;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  assign bus_in = ~(drv | ext_low);

  always #2.5 clk = ~clk;

  share_bus_node dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .bus_in       (bus_in),
    .bus_drive_low(drv),
    .cur_a        (cur_a),
    .cur_b        (cur_b),
    .chan_sel     (chan_sel),
    .share_word   (share)
  );

  // {cur_a, cur_b, chan_sel, other_on, other_word, expected_share}
  localparam logic [49:0] VECS [0:7] = '{
    {16'hA53C, 16'h1234, 1'b0, 1'b0, 8'h00, 8'hA5},
    {16'hA53C, 16'h1234, 1'b1, 1'b0, 8'h00, 8'h12},
    {16'h80FF, 16'h7F00, 1'b0, 1'b1, 8'h7F, 8'h7F},
    {16'h3300, 16'h0000, 1'b0, 1'b1, 8'hC0, 8'h33},
    {16'h5A00, 16'hFFFF, 1'b0, 1'b1, 8'h5A, 8'h5A},
    {16'hFF00, 16'h0000, 1'b1, 1'b1, 8'hFF, 8'h00},
    {16'hFFFF, 16'h0101, 1'b0, 1'b0, 8'h00, 8'hFF},
    {16'h6E01, 16'h9999, 1'b0, 1'b1, 8'h6F, 8'h6E}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] dut_w, input logic [7:0] oth_w, input bit oth_on,
                           input bit kill_stop, output logic [7:0] bus_w);
    bit dut_act = 1'b1;
    bit oth_act = oth_on;
    bus_w = '0;
    ext_low = 1'b1;
    tick();
    for (int i = 7; i >= 0; i--) begin
      bit exp_drv;
      bit lvl;
      exp_drv = dut_act && !dut_w[i];
      chk(drv == exp_drv, "R4 R5 data slot drive", drv, exp_drv);
      ext_low = oth_act && !oth_w[i];
      lvl = !(exp_drv || ext_low);
      bus_w[i] = lvl;
      if (dut_act && dut_w[i] && !lvl) dut_act = 1'b0;
      if (oth_act && oth_w[i] && !lvl) oth_act = 1'b0;
      tick();
    end
    ext_low = kill_stop;
    chk(drv == 1'b0, "R3 stop slot released", drv, 0);
    tick();
    ext_low = 1'b0;
  endtask

  task automatic other_frame(input logic [7:0] w);
    ext_low = 1'b1;
    tick();
    chk(drv == 1'b0, "R8 silent while unsynced", drv, 0);
    for (int i = 7; i >= 0; i--) begin
      ext_low = !w[i];
      tick();
      chk(drv == 1'b0, "R8 silent while unsynced", drv, 0);
    end
    ext_low = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] bw;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk(drv == 1'b0 && share == 8'h00, "R1 reset state", {drv, share}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // lone node: silent for 9 released slots, starts on the 10th
    cur_a = 16'h9600; chan_sel = 1'b0;
    for (int k = 0; k < 9; k++) tick();
    chk(drv == 1'b0, "R8 no drive before start run", drv, 0);
    tick();
    chk(drv == 1'b1, "R10 self start after long release", drv, 1);
    run_frame(8'h96, 8'h00, 1'b0, 1'b0, bw);
    chk(share == 8'h96, "R10 R6 lone frame word", share, 8'h96);

    // vector table
    for (int v = 0; v < 8; v++) begin
      logic [7:0] dw;
      cur_a    = VECS[v][49:34];
      cur_b    = VECS[v][33:18];
      chan_sel = VECS[v][17];
      dw = chan_sel ? cur_b[15:8] : cur_a[15:8];
      run_frame(dw, VECS[v][7:0] == 8'h00 ? 8'h00 : VECS[v][15:8], VECS[v][16], 1'b0, bw);
      chk(bw == VECS[v][7:0], "R5 wired bus word", bw, VECS[v][7:0]);
      chk(share == VECS[v][7:0], "R2 R6 share after stop", share, VECS[v][7:0]);
    end

    // corrupted stop slot
    held = share;
    cur_a = 16'h2100; chan_sel = 1'b0;
    run_frame(8'h21, 8'h4B, 1'b1, 1'b1, bw);
    chk(share == held, "R7 discarded frame keeps share", share, held);

    // now unsynced: frames on the wire with no long release are not joined
    other_frame(8'h4B);
    other_frame(8'h4B);
    chk(share == held, "R8 unsynced node ignores frames", share, held);
    for (int k = 0; k < 6; k++) tick();
    chk(drv == 1'b0, "R8 synced but idle", drv, 0);
    run_frame(8'h21, 8'h4B, 1'b1, 1'b0, bw);
    chk(share == 8'h21, "R9 joins after stop", share, 8'h21);

    // drive held between ticks, then reset in mid frame
    ext_low = 1'b1;
    tick();
    ext_low = 1'b0;
    chk(drv == 1'b1, "R4 first data bit drive", drv, 1);
    repeat (8) @(negedge clk);
    chk(drv == 1'b1, "R3 no change without tick", drv, 1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(drv == 1'b0 && share == 8'h00, "R1 reset mid frame", {drv, share}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule